// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Transmitter

This block is the device-side output stage of a converter-style data port. A result word, offered on a parallel input, is shifted out MSB first on a single data line. The shift follows a free-running serial clock, and a frame sync line marks the frame boundaries. A host starts a read by pulling the read strobe low while chip select is low. The block then captures the word, enables its data and sync drivers and raises a bus-busy flag. It walks a fixed schedule counted in serial-clock rising edges, and at the end of the schedule it releases the lines again.

A mode input, sampled when the read starts, selects the framing. In word framing the whole word forms one frame. In byte framing the upper half goes first and the lower half follows at once in a second frame of half the length. The bit stream on the data line is the same in both modes; only the sync pattern differs. The three-state outputs are modeled as a value plus a separate output-enable. Raising chip select during a read abandons the read and turns both drivers off.

Top module: `fsx_serial_tx`

## Requirements
- R1: A falling edge on `rd_n`, seen while `cs_n` is low and `busy_o` is low, starts a read. On the next `clk` edge `busy_o`, `sync_oe` and `sdata_oe` all go to 1.
- R2: A falling edge on `rd_n` while `cs_n` is high has no effect. `busy_o`, `sync_oe` and `sdata_oe` stay 0.
- R3: Number the serial-clock rising edges after the start 0, 1, 2 and so on. `sync_o` is 1 for exactly the serial-clock period that follows edges 0 and 16 in word framing (`byte_mode`=0). In byte framing (`byte_mode`=1) it is 1 after edges 0, 8 and 16. It is 0 after every other edge of the read.
- R4: The word is driven MSB first. Bit 15 appears at edge 2, bit 14 at edge 3, and so on, with bit 0 at edge 17. Each bit is updated on the clock edge where `sclk_o` rises.
- R5: In byte framing, bits 15..8 appear at edges 2..9 and bits 7..0 follow without a gap at edges 10..17.
- R6: `word_in` is captured when the read starts. Changing it later does not alter the bits sent in that read.
- R7: At edge 18 `busy_o`, `sync_oe` and `sdata_oe` return to 0, and the block accepts a new read.
- R8: If `cs_n` is 1 during a read, then on the next `clk` edge `busy_o`, `sync_oe` and `sdata_oe` become 0. They stay 0 until a new read starts.
- R9: A second falling edge on `rd_n` during a read is ignored, and the read in progress completes unchanged.
- R10: `sclk_o` runs at all times, including when idle and during reset release. It has a period of 2*`SCLK_HALF` `clk` cycles.
- R11: `sdata_o` is 0 at edges 0 and 1, before the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe; a falling edge starts a read |
| byte_mode | input | 1 | 0 selects word framing, 1 selects byte framing; sampled at start |
| word_in | input | WORD_W | Parallel result word |
| sclk_o | output | 1 | Free-running serial clock |
| sync_o | output | 1 | Frame sync value |
| sync_oe | output | 1 | Output enable of the sync line |
| sdata_o | output | 1 | Serial data value |
| sdata_oe | output | 1 | Output enable of the data line |
| busy_o | output | 1 | High while a read is in progress |

## Verification
Reads are run with an alternating word and with a walking-edge word in both framings. The alternating word shows whether each bit sits at its own edge. The walking-edge word exposes a stream that is shifted by one edge or reversed. Comparing the two framings on the same word shows that only the sync pattern changes between them. Further cases cover strobes that arrive with chip select high or during a read, a result input that changes mid-frame, and a read abandoned by chip select. Each one is checked against the bus-busy and enable lines both before and after the next read.

// File: rtl/fsx_pkg.sv
package fsx_pkg;

   typedef enum logic {
      FSX_IDLE  = 1'b0,
      FSX_SHIFT = 1'b1
   } fsx_state_e;

   function automatic int fsx_cnt_bits(input int word_w);
      return $clog2(word_w + 3);
   endfunction

endpackage

// File: rtl/fsx_sclk_gen.sv
module fsx_sclk_gen #(
   parameter int SCLK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic sclk,
   output logic rise_tick
);

   logic sclk_q;

   initial begin
      assert (SCLK_HALF >= 1) else $error("SCLK_HALF must be at least 1");
   end

   generate
      if (SCLK_HALF == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sclk_q <= 1'b0;
            else        sclk_q <= !sclk_q;
         end
         assign rise_tick = !sclk_q;
      end else begin : g_div
         localparam int DW = $clog2(SCLK_HALF);
         localparam logic [DW-1:0] DIV_END = DW'(SCLK_HALF - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q  <= '0;
               sclk_q <= 1'b0;
            end else if (div_q == DIV_END) begin
               div_q  <= '0;
               sclk_q <= !sclk_q;
            end else begin
               div_q  <= div_q + 1'b1;
            end
         end
         assign rise_tick = (div_q == DIV_END) && !sclk_q;
      end
   endgenerate

   assign sclk = sclk_q;

   // R10: the serial clock rises exactly one cycle after a tick
   a_r10_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick |=> sclk_q);
   a_r10_no_stray_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_tick |=> !$rose(sclk_q));

endmodule

// File: rtl/fsx_frame_seq.sv
module fsx_frame_seq
   import fsx_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic byte_mode,
   input  logic tick,
   output logic busy,
   output logic oe,
   output logic sync,
   output logic load,
   output logic shift_en
);

   localparam int CW     = fsx_cnt_bits(WORD_W);
   localparam int HALF_W = WORD_W / 2;
   localparam logic [CW-1:0] LAST_EDGE = CW'(WORD_W + 2);
   localparam logic [CW-1:0] SYNC_MAX  = CW'(WORD_W);
   localparam logic [CW-1:0] FIRST_BIT = CW'(2);
   localparam logic [CW-1:0] FINAL_BIT = CW'(WORD_W + 1);
   localparam logic [CW-1:0] LEN_WORD  = CW'(WORD_W);
   localparam logic [CW-1:0] LEN_BYTE  = CW'(HALF_W);

   fsx_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          mode_q;
   logic          rd_q;
   logic          busy_q, oe_q, sync_q;
   logic          sync_hit;
   logic          abort;

   always_comb begin
      if (mode_q) sync_hit = (cnt_q <= SYNC_MAX) && ((cnt_q % LEN_BYTE) == '0);
      else        sync_hit = (cnt_q <= SYNC_MAX) && ((cnt_q % LEN_WORD) == '0);
   end

   assign load     = (state_q == FSX_IDLE) && rd_q && !rd_n && !cs_n;
   assign abort    = (state_q == FSX_SHIFT) && cs_n;
   assign shift_en = tick && (state_q == FSX_SHIFT) && !cs_n
                     && (cnt_q >= FIRST_BIT) && (cnt_q <= FINAL_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FSX_IDLE;
         cnt_q   <= '0;
         mode_q  <= 1'b0;
         rd_q    <= 1'b1;
         busy_q  <= 1'b0;
         oe_q    <= 1'b0;
         sync_q  <= 1'b0;
      end else begin
         rd_q <= rd_n;
         if (abort) begin
            state_q <= FSX_IDLE;
            busy_q  <= 1'b0;
            oe_q    <= 1'b0;
            sync_q  <= 1'b0;
         end else begin
            case (state_q)
               FSX_IDLE: begin
                  if (load) begin
                     state_q <= FSX_SHIFT;
                     cnt_q   <= '0;
                     mode_q  <= byte_mode;
                     busy_q  <= 1'b1;
                     oe_q    <= 1'b1;
                     sync_q  <= 1'b0;
                  end
               end
               FSX_SHIFT: begin
                  if (tick) begin
                     if (cnt_q == LAST_EDGE) begin
                        state_q <= FSX_IDLE;
                        busy_q  <= 1'b0;
                        oe_q    <= 1'b0;
                        sync_q  <= 1'b0;
                     end else begin
                        sync_q  <= sync_hit;
                        cnt_q   <= cnt_q + 1'b1;
                     end
                  end
               end
               default: state_q <= FSX_IDLE;
            endcase
         end
      end
   end

   assign busy = busy_q;
   assign oe   = oe_q;
   assign sync = sync_q;

   // R1: a qualified strobe fall raises busy and the enables
   a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) && !cs_n && !busy_q) |=> (busy_q && oe_q));
   // R8: chip select high during a read drops everything
   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cs_n) |=> (!busy_q && !oe_q));
   // R9: the edge count moves only on serial-clock ticks
   a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !cs_n && !tick) |=> $stable(cnt_q));
   // R3: sync is only asserted on an enabled line
   a_r3_sync_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |-> oe_q);

endmodule

// File: rtl/fsx_word_shifter.sv
module fsx_word_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift_en,
   input  logic [WORD_W-1:0] word_in,
   output logic              bit_out
);

   logic [WORD_W-1:0] shreg_q;
   logic              bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         bit_q   <= 1'b0;
      end else if (load) begin
         shreg_q <= word_in;
         bit_q   <= 1'b0;
      end else if (shift_en) begin
         bit_q   <= shreg_q[WORD_W-1];
         shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
      end
   end

   assign bit_out = bit_q;

   // R6: the captured word only moves on load or shift
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift_en) |=> $stable(shreg_q));
   // R4: each shift emits the previous top bit
   a_r4_msb_out: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (bit_q == $past(shreg_q[WORD_W-1])));

endmodule

// File: rtl/fsx_serial_tx.sv
module fsx_serial_tx #(
   parameter int WORD_W    = 16,
   parameter int SCLK_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              byte_mode,
   input  logic [WORD_W-1:0] word_in,
   output logic              sclk_o,
   output logic              sync_o,
   output logic              sync_oe,
   output logic              sdata_o,
   output logic              sdata_oe,
   output logic              busy_o
);

   logic tick, load, shift_en, oe, sync, busy, bit_out;

   initial begin
      assert (WORD_W >= 4 && (WORD_W % 2) == 0)
         else $error("WORD_W must be even and at least 4");
   end

   fsx_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (sclk_o),
      .rise_tick (tick)
   );

   fsx_frame_seq #(.WORD_W(WORD_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .rd_n      (rd_n),
      .byte_mode (byte_mode),
      .tick      (tick),
      .busy      (busy),
      .oe        (oe),
      .sync      (sync),
      .load      (load),
      .shift_en  (shift_en)
   );

   fsx_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .shift_en (shift_en),
      .word_in  (word_in),
      .bit_out  (bit_out)
   );

   assign sync_o   = sync;
   assign sync_oe  = oe;
   assign sdata_o  = bit_out;
   assign sdata_oe = oe;
   assign busy_o   = busy;

   // R7: outside a read both drivers are off
   a_r7_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!sync_oe && !sdata_oe));

endmodule

// File: tb/fsx_serial_tx_test.sv
`timescale 1ns/1ps
module fsx_serial_tx_test;

   localparam int W    = 16;
   localparam int HALF = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         rd_n = 1'b1;
   logic         byte_mode = 1'b0;
   logic [W-1:0] word_in = '0;
   logic         sclk_o, sync_o, sync_oe, sdata_o, sdata_oe, busy_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = !clk;

   fsx_serial_tx #(.WORD_W(W), .SCLK_HALF(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
      .byte_mode(byte_mode), .word_in(word_in), .sclk_o(sclk_o),
      .sync_o(sync_o), .sync_oe(sync_oe), .sdata_o(sdata_o),
      .sdata_oe(sdata_oe), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drives a strobe fall with chip select low and checks R1 one clock later.
   task automatic start_read(input logic [W-1:0] w, input logic mode);
      @(negedge clk);
      word_in = w; byte_mode = mode; cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      chk(busy_o && sync_oe && sdata_oe, "R1 start raises busy/oe",
          {busy_o, sync_oe, sdata_oe}, 3'b111);
   endtask

   // Follows one read edge by edge. scramble: change word_in after start (R6);
   // restrobe: pulse rd_n low mid-read (R9).
   task automatic run_frame(input logic [W-1:0] w, input logic mode,
                            input bit scramble, input bit restrobe, input string tag);
      int   idx = 0;
      int   sync_bad = 0, data_bad = 0, pre_bad = 0, oe_bad = 0;
      int   guard = 0;
      logic sp, bp;
      logic [W-1:0] got = '0;
      logic [W-1:0] sync_got = '0;
      logic [W-1:0] sync_exp = '0;
      start_read(w, mode);
      sp = sclk_o; bp = busy_o;
      while (bp && guard < 400) begin
         @(negedge clk);
         guard++;
         if (sclk_o && !sp && bp) begin
            if (idx == 1) rd_n = 1'b1;
            if (idx == 1 && scramble) word_in = ~w;
            if (idx == 5 && restrobe) rd_n = 1'b0;
            if (idx == 7 && restrobe) rd_n = 1'b1;
            if (idx <= W + 1) begin
               if (!sync_oe || !sdata_oe || !busy_o) oe_bad++;
               if (idx <= W && sync_o) sync_got[idx % W] = 1'b1;
               if (sync_o != ((idx <= W) && ((idx % (mode ? W/2 : W)) == 0))) sync_bad++;
               if (idx < 2 && sdata_o) pre_bad++;
               if (idx >= 2) got[W-1-(idx-2)] = sdata_o;
            end else begin
               chk(!busy_o && !sync_oe && !sdata_oe, {"R7 release at last edge ", tag},
                   {busy_o, sync_oe, sdata_oe}, 0);
            end
            idx++;
         end
         sp = sclk_o; bp = busy_o;
      end
      sync_exp[0] = 1'b1;
      if (mode) sync_exp[W/2] = 1'b1;
      chk(idx == W + 3, {"R7 edge count ", tag}, idx, W + 3);
      chk(oe_bad == 0, {"R1 enables held ", tag}, oe_bad, 0);
      chk(sync_bad == 0, {"R3 sync pattern ", tag}, sync_got, sync_exp);
      chk(pre_bad == 0, {"R11 data low before MSB ", tag}, pre_bad, 0);
      chk(got == w, {(mode ? "R5 byte order " : "R4 word order "), tag}, got, w);
      rd_n = 1'b1;
   endtask

   task automatic t_reset;
      chk(!busy_o && !sync_oe && !sdata_oe, "R7 reset idle", {busy_o, sync_oe, sdata_oe}, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy_o && !sync_oe && !sdata_oe, "R7 idle after reset",
          {busy_o, sync_oe, sdata_oe}, 0);
   endtask

   task automatic t_sclk_period;
      int n = 0, bad = 0, cyc = 0;
      logic sp = sclk_o;
      int last = -1;
      while (n < 4 && cyc < 100) begin
         @(negedge clk); cyc++;
         if (sclk_o && !sp) begin
            if (last >= 0 && (cyc - last) != 2 * HALF) bad++;
            last = cyc; n++;
         end
         sp = sclk_o;
      end
      chk(n == 4 && bad == 0, "R10 sclk free-running period", bad, 0);
   endtask

   task automatic t_cs_high_strobe;
      int bad = 0;
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (busy_o || sync_oe || sdata_oe) bad++;
      end
      rd_n = 1'b1;
      chk(bad == 0, "R2 strobe with cs high ignored", bad, 0);
   endtask

   task automatic t_abort;
      int bad = 0;
      start_read(16'hC3A5, 1'b0);
      repeat (12) @(negedge clk);
      rd_n = 1'b1;
      cs_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !sync_oe && !sdata_oe, "R8 abort releases",
          {busy_o, sync_oe, sdata_oe}, 0);
      cs_n = 1'b0;
      repeat (40) begin
         @(negedge clk);
         if (busy_o || sync_oe || sdata_oe) bad++;
      end
      chk(bad == 0, "R8 stays released", bad, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_sclk_period();
      t_cs_high_strobe();
      run_frame(16'hAAAA, 1'b0, 1'b0, 1'b0, "alt word");
      run_frame(16'h8001, 1'b0, 1'b0, 1'b0, "edge word");
      run_frame(16'hAAAA, 1'b1, 1'b0, 1'b0, "alt byte");
      run_frame(16'h0F81, 1'b1, 1'b0, 1'b0, "edge byte");
      run_frame(16'h5A3C, 1'b0, 1'b1, 1'b0, "R6 capture");
      run_frame(16'h1234, 1'b1, 1'b0, 1'b1, "R9 restrobe");
      t_abort();
      run_frame(16'hFE01, 1'b0, 1'b0, 1'b0, "after abort");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule